// File: doc/BRIEF.md
# Counter CSR Privilege Gate

This block keeps a small set of 64-bit event counters in the layout of a RISC-V style control-and-status register space. It also decides whether a request to one of those registers is legal at the privilege level of the requester. The counters are:

- a cycle counter that advances on every clock;
- a retired-instruction counter driven by a retire pulse;
- a pass-through time value;
- a parameterised number of hardware performance counters, each driven by its own event input.

Two writable enable registers control which counters lower privilege levels may read. The machine-level register governs supervisor and user reads. The supervisor-level register further restricts user reads.

Each request carries an address, a privilege level, an operation (write, set-bits or clear-bits), a flag that says the source register is x0, and write data. One cycle later the block returns either the register value or an illegal-instruction flag. A set-bits request whose source is x0 is the plain read form used by cycle-read pseudo-instructions. It never writes, so it is accepted on read-only counter addresses. Machine software may preset the counters through a separate machine-only address range.

Top module: `ctr_csr_gate`

## Requirements
- R1: After reset every counter reads zero. The cycle counter (index 0) advances by one on every clock. The retired-instruction counter (index 2) advances on each clock where `retire_i` is high. Performance counter n (index n, n = 3 to 2+NUM_HPM) advances on each clock where `hpm_evt_i[n-3]` is high. Index 1 returns `time_i` as sampled in the request cycle.
- R2: Both enable registers use one bit per counter index: bit 0 cycle, bit 1 time, bit 2 retired instructions, bit n performance counter n. Bits for unimplemented indices always read zero, even after ones are written to them. Both registers reset to zero.
- R3: A machine-mode (priv 3) read of an implemented user counter at 0xC00+index is legal whatever the enable bits hold.
- R4: A supervisor-mode (priv 1) read of a user counter is legal only when the matching machine-level enable bit is set.
- R5: A user-mode (priv 0) read of a user counter is legal only when the matching bits of both the machine-level and supervisor-level enable registers are set.
- R6: Operation codes are 0 write, 1 set-bits, 2 clear-bits. Addresses 0xC00 to 0xC1F are read-only. A write (any source), or a set-bits or clear-bits whose source is not x0, is illegal there at any privilege. A set-bits or clear-bits whose source is x0 is a pure read.
- R7: The machine-level enable register sits at 0x306 and only machine mode may access it. The supervisor-level enable register sits at 0x106 and may be accessed from supervisor or machine mode. Any other access to either register is illegal.
- R8: At 0xB00+index, machine mode may read and modify implemented counters other than index 1. The written value is the write data, old OR data, or old AND NOT data. A read on the next cycle returns the new value. Access from below machine mode is illegal.
- R9: The response appears one cycle after the request. An illegal response carries zero data and changes no state. Unmapped addresses and unimplemented counter indices are illegal.
- R10: Privilege code 2 and operation code 3 make every request illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_i | input | 1 | One retired instruction this cycle |
| hpm_evt_i | input | NUM_HPM | Per-performance-counter event pulses |
| time_i | input | 64 | Current time value |
| req_valid_i | input | 1 | Request present this cycle |
| req_addr_i | input | 12 | Register address |
| req_priv_i | input | 2 | Requester privilege: 0 user, 1 supervisor, 3 machine |
| req_op_i | input | 2 | 0 write, 1 set-bits, 2 clear-bits |
| req_src_x0_i | input | 1 | Source register is x0 |
| req_wdata_i | input | 64 | Write / mask data |
| rsp_valid_o | output | 1 | Response present |
| rsp_illegal_o | output | 1 | Request raised an illegal-instruction exception |
| rsp_rdata_o | output | 64 | Old register value, zero when illegal |

## Verification
Every result is due one clock after its request. The bench drives a request on a falling edge and samples the response on the next falling edge, after exactly one rising edge has registered it. Counter values follow from that timing:

- A write is visible to a read issued on the following cycle.
- Back-to-back reads of the cycle counter differ by exactly one.
- Event counts equal the number of rising edges on which the event input was held high.

The privilege gate is swept over all 1024 pairs of implemented enable-bit patterns for every counter index and privilege level, and each legality is predicted arithmetically.

// File: rtl/ctr_csr_pkg.sv
package ctr_csr_pkg;

  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_BAD   = 2'd3
  } csr_op_e;

  typedef enum logic [2:0] {
    K_NONE,
    K_UCTR,
    K_MCTR,
    K_MEN,
    K_SEN
  } csr_kind_e;

  localparam logic [6:0]  UCTR_BASE = 7'h60;   // 0xC00 >> 5
  localparam logic [6:0]  MCTR_BASE = 7'h58;   // 0xB00 >> 5
  localparam logic [11:0] ADDR_MEN  = 12'h306;
  localparam logic [11:0] ADDR_SEN  = 12'h106;

  // New register value for a read-modify-write operation
  function automatic logic [63:0] csr_apply(csr_op_e op, logic [63:0] old_v,
                                            logic [63:0] d);
    case (op)
      OP_WRITE: csr_apply = d;
      OP_SET:   csr_apply = old_v | d;
      OP_CLEAR: csr_apply = old_v & ~d;
      default:  csr_apply = old_v;
    endcase
  endfunction

  // Counter read gate by privilege and enable bits
  function automatic logic ctr_gate_ok(priv_e p, logic m_bit, logic s_bit);
    case (p)
      PRIV_M:  ctr_gate_ok = 1'b1;
      PRIV_S:  ctr_gate_ok = m_bit;
      PRIV_U:  ctr_gate_ok = m_bit & s_bit;
      default: ctr_gate_ok = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ctr_csr_bank.sv
module ctr_csr_bank #(
  parameter int NUM_HPM = 2,
  parameter int CNT_W   = 64,
  localparam int NUM_CTR = 3 + NUM_HPM
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retire_i,
  input  logic [NUM_HPM-1:0] hpm_evt_i,
  input  logic [CNT_W-1:0] time_i,
  input  logic             wr_en_i,
  input  logic [4:0]       wr_idx_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] cnt_o [NUM_CTR]
);

  logic [NUM_CTR-1:0] inc;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    if (i == 1) begin : g_time
      assign inc[i]   = 1'b0;
      assign cnt_o[i] = time_i;
    end else begin : g_reg
      if (i == 0) begin : g_cy
        assign inc[i] = 1'b1;
      end else if (i == 2) begin : g_ir
        assign inc[i] = retire_i;
      end else begin : g_hpm
        assign inc[i] = hpm_evt_i[i-3];
      end
      logic [CNT_W-1:0] val_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  val_q <= '0;
        else if (wr_en_i && wr_idx_i == 5'(i))       val_q <= wr_data_i;
        else if (inc[i])                             val_q <= val_q + 1'b1;
      end
      assign cnt_o[i] = val_q;
    end
  end

  // R1: cycle counter steps by one whenever it is not written
  assert_cycle_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !($past(wr_en_i) && $past(wr_idx_i) == 5'd0))
      |-> cnt_o[0] == $past(cnt_o[0]) + 1'b1);

  // R8: a machine write to the retired-instruction counter lands as written
  assert_mwrite_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en_i) && $past(wr_idx_i) == 5'd2)
      |-> cnt_o[2] == $past(wr_data_i));

endmodule

// File: rtl/ctr_csr_enables.sv
module ctr_csr_enables #(
  parameter int NUM_HPM = 2,
  localparam int NUM_CTR = 3 + NUM_HPM,
  localparam logic [31:0] IMPL_MASK = 32'((64'd1 << NUM_CTR) - 64'd1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        men_wr_i,
  input  logic        sen_wr_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] men_o,
  output logic [31:0] sen_o
);

  logic [31:0] men_q, sen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      men_q <= '0;
      sen_q <= '0;
    end else begin
      if (men_wr_i) men_q <= wr_data_i & IMPL_MASK;
      if (sen_wr_i) sen_q <= wr_data_i & IMPL_MASK;
    end
  end

  assign men_o = men_q;
  assign sen_o = sen_q;

  // R9: enable registers change only on an accepted write
  assert_men_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(men_wr_i)) |-> $stable(men_q));
  assert_sen_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(sen_wr_i)) |-> $stable(sen_q));

endmodule

// File: rtl/ctr_csr_decode.sv
module ctr_csr_decode
  import ctr_csr_pkg::*;
#(
  parameter int NUM_HPM = 2,
  localparam int NUM_CTR = 3 + NUM_HPM,
  localparam logic [31:0] IMPL_MASK = 32'((64'd1 << NUM_CTR) - 64'd1)
) (
  input  logic        valid_i,
  input  logic [11:0] addr_i,
  input  priv_e       priv_i,
  input  csr_op_e     op_i,
  input  logic        src_x0_i,
  input  logic [31:0] men_i,
  input  logic [31:0] sen_i,
  output csr_kind_e   kind_o,
  output logic [4:0]  idx_o,
  output logic        legal_o,
  output logic        wr_intent_o
);

  logic impl;

  always_comb begin
    kind_o = K_NONE;
    if (addr_i[11:5] == UCTR_BASE)      kind_o = K_UCTR;
    else if (addr_i[11:5] == MCTR_BASE) kind_o = K_MCTR;
    else if (addr_i == ADDR_MEN)        kind_o = K_MEN;
    else if (addr_i == ADDR_SEN)        kind_o = K_SEN;
  end

  assign idx_o       = addr_i[4:0];
  assign impl        = IMPL_MASK[idx_o];
  assign wr_intent_o = (op_i == OP_WRITE) || !src_x0_i;

  always_comb begin
    case (kind_o)
      K_UCTR:  legal_o = impl && !wr_intent_o && ctr_gate_ok(priv_i, men_i[idx_o], sen_i[idx_o]);
      K_MCTR:  legal_o = impl && (idx_o != 5'd1) && (priv_i == PRIV_M);
      K_MEN:   legal_o = (priv_i == PRIV_M);
      K_SEN:   legal_o = (priv_i == PRIV_M) || (priv_i == PRIV_S);
      default: legal_o = 1'b0;
    endcase
    if (!valid_i || priv_i == PRIV_RSV || op_i == OP_BAD) legal_o = 1'b0;
  end

endmodule

// File: rtl/ctr_csr_gate.sv
module ctr_csr_gate
  import ctr_csr_pkg::*;
#(
  parameter int NUM_HPM = 2,
  parameter int CNT_W   = 64,
  localparam int NUM_CTR = 3 + NUM_HPM
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               retire_i,
  input  logic [NUM_HPM-1:0] hpm_evt_i,
  input  logic [CNT_W-1:0]   time_i,
  input  logic               req_valid_i,
  input  logic [11:0]        req_addr_i,
  input  logic [1:0]         req_priv_i,
  input  logic [1:0]         req_op_i,
  input  logic               req_src_x0_i,
  input  logic [CNT_W-1:0]   req_wdata_i,
  output logic               rsp_valid_o,
  output logic               rsp_illegal_o,
  output logic [CNT_W-1:0]   rsp_rdata_o
);

  logic [CNT_W-1:0] cnt [NUM_CTR];
  logic [31:0]      men, sen;
  csr_kind_e        kind;
  logic [4:0]       idx;
  logic             legal, wr_intent;
  logic [CNT_W-1:0] rd_val, new_val;
  logic             ctr_wr, men_wr, sen_wr;

  ctr_csr_decode #(.NUM_HPM(NUM_HPM)) u_dec (
    .valid_i     (req_valid_i),
    .addr_i      (req_addr_i),
    .priv_i      (priv_e'(req_priv_i)),
    .op_i        (csr_op_e'(req_op_i)),
    .src_x0_i    (req_src_x0_i),
    .men_i       (men),
    .sen_i       (sen),
    .kind_o      (kind),
    .idx_o       (idx),
    .legal_o     (legal),
    .wr_intent_o (wr_intent)
  );

  always_comb begin
    rd_val = '0;
    case (kind)
      K_UCTR, K_MCTR: if (int'(idx) < NUM_CTR) rd_val = cnt[idx];
      K_MEN:          rd_val = CNT_W'(men);
      K_SEN:          rd_val = CNT_W'(sen);
      default:        rd_val = '0;
    endcase
  end

  assign new_val = csr_apply(csr_op_e'(req_op_i), rd_val, req_wdata_i);
  assign ctr_wr  = legal && wr_intent && (kind == K_MCTR);
  assign men_wr  = legal && wr_intent && (kind == K_MEN);
  assign sen_wr  = legal && wr_intent && (kind == K_SEN);

  ctr_csr_bank #(.NUM_HPM(NUM_HPM), .CNT_W(CNT_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .retire_i  (retire_i),
    .hpm_evt_i (hpm_evt_i),
    .time_i    (time_i),
    .wr_en_i   (ctr_wr),
    .wr_idx_i  (idx),
    .wr_data_i (new_val),
    .cnt_o     (cnt)
  );

  ctr_csr_enables #(.NUM_HPM(NUM_HPM)) u_en (
    .clk       (clk),
    .rst_n     (rst_n),
    .men_wr_i  (men_wr),
    .sen_wr_i  (sen_wr),
    .wr_data_i (new_val[31:0]),
    .men_o     (men),
    .sen_o     (sen)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o   <= 1'b0;
      rsp_illegal_o <= 1'b0;
      rsp_rdata_o   <= '0;
    end else begin
      rsp_valid_o   <= req_valid_i;
      rsp_illegal_o <= req_valid_i && !legal;
      rsp_rdata_o   <= legal ? rd_val : '0;
    end
  end

  // R6: any write intent at a read-only user counter is refused
  assert_user_ro_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_addr_i[11:5] == UCTR_BASE &&
     (req_op_i == 2'd0 || !req_src_x0_i)) |=> rsp_illegal_o);

  // R4: supervisor read blocked by a clear machine-level bit
  assert_s_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_addr_i[11:5] == UCTR_BASE && req_priv_i == 2'd1 &&
     !men[req_addr_i[4:0]]) |=> rsp_illegal_o);

  // R5: user read blocked by a clear supervisor-level bit
  assert_u_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_addr_i[11:5] == UCTR_BASE && req_priv_i == 2'd0 &&
     !sen[req_addr_i[4:0]]) |=> rsp_illegal_o);

  // R3: machine read of an implemented user counter always accepted
  assert_m_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_addr_i[11:5] == UCTR_BASE && req_priv_i == 2'd3 &&
     int'(req_addr_i[4:0]) < NUM_CTR && req_src_x0_i &&
     (req_op_i == 2'd1 || req_op_i == 2'd2)) |=> !rsp_illegal_o);

  // R9: an illegal response carries no data
  assert_illegal_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_illegal_o |-> rsp_rdata_o == '0);

endmodule

// File: tb/ctr_csr_gate_tb.sv
module ctr_csr_gate_tb;

  localparam int NUM_HPM = 2;
  localparam int NCTR    = 3 + NUM_HPM;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               retire = 1'b0;
  logic [NUM_HPM-1:0] hpm_evt = '0;
  logic [63:0]        time_v = 64'h1234_5678_9ABC_DEF0;
  logic               req_valid = 1'b0;
  logic [11:0]        req_addr = '0;
  logic [1:0]         req_priv = '0;
  logic [1:0]         req_op = '0;
  logic               req_x0 = 1'b1;
  logic [63:0]        req_wdata = '0;
  logic               rsp_valid, rsp_illegal;
  logic [63:0]        rsp_rdata;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ctr_csr_gate #(.NUM_HPM(NUM_HPM), .CNT_W(64)) u_dut (
    .clk(clk), .rst_n(rst_n), .retire_i(retire), .hpm_evt_i(hpm_evt),
    .time_i(time_v), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_priv_i(req_priv), .req_op_i(req_op), .req_src_x0_i(req_x0),
    .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid),
    .rsp_illegal_o(rsp_illegal), .rsp_rdata_o(rsp_rdata)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called on a falling edge; returns on the next falling edge with the response
  task automatic access(input logic [11:0] a, input logic [1:0] p,
                        input logic [1:0] op, input logic x0,
                        input logic [63:0] d, output logic ill,
                        output logic [63:0] rd);
    req_valid = 1'b1; req_addr = a; req_priv = p; req_op = op;
    req_x0 = x0; req_wdata = d;
    @(negedge clk);
    ill = rsp_illegal; rd = rsp_rdata;
    if (!rsp_valid) check(1'b0, "R9 valid", 64'(rsp_valid), 64'd1);
    req_valid = 1'b0;
  endtask

  // Bench-side legality for a user-counter read in the x0 set-bits form
  function automatic bit want_legal(int c, int p, logic [31:0] m, logic [31:0] s);
    if (c >= NCTR) return 1'b0;
    if (p == 3) return 1'b1;
    if (p == 1) return m[c];
    if (p == 0) return m[c] && s[c];
    return 1'b0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic ill;
    logic [63:0] rd, rd2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state (R1, R2)
    access(12'hC02, 2'd3, 2'd1, 1'b1, 64'd0, ill, rd);
    check(!ill && rd == 0, "R1 instret reset", rd, 64'd0);
    access(12'hC03, 2'd3, 2'd1, 1'b1, 64'd0, ill, rd);
    check(!ill && rd == 0, "R1 hpm3 reset", rd, 64'd0);
    access(12'h306, 2'd3, 2'd1, 1'b1, 64'd0, ill, rd);
    check(!ill && rd == 0, "R2 men reset", rd, 64'd0);
    access(12'h106, 2'd1, 2'd1, 1'b1, 64'd0, ill, rd);
    check(!ill && rd == 0, "R2 sen reset", rd, 64'd0);

    // Unimplemented enable bits read zero (R2)
    access(12'h306, 2'd3, 2'd0, 1'b0, 64'hFFFF_FFFF, ill, rd);
    access(12'h306, 2'd3, 2'd1, 1'b1, 64'd0, ill, rd);
    check(rd == 64'h1F, "R2 men mask", rd, 64'h1F);

    // Privilege sweep over all implemented enable patterns (R3 R4 R5 R9)
    for (int m = 0; m < 32; m++) begin
      for (int s = 0; s < 32; s++) begin
        access(12'h306, 2'd3, 2'd0, 1'b0, 64'(m), ill, rd);
        access(12'h106, 2'd1, 2'd0, 1'b0, 64'(s), ill, rd);
        for (int c = 0; c < 6; c++) begin
          for (int pi = 0; pi < 3; pi++) begin
            int p;
            bit w;
            p = (pi == 2) ? 3 : pi;
            w = want_legal(c, p, 32'(m), 32'(s));
            access(12'hC00 + 12'(c), 2'(p), 2'd1, 1'b1, 64'd0, ill, rd);
            check(ill == !w, (p == 3) ? "R3 gate" : (p == 1) ? "R4 gate" : "R5 gate",
                  64'(ill), 64'(!w));
            if (ill) check(rd == 0, "R9 zero data", rd, 64'd0);
            else if (c >= 2) check(rd == 0, "R1 idle counter", rd, 64'd0);
          end
        end
      end
    end

    // Time pass-through (R1)
    access(12'hC01, 2'd3, 2'd1, 1'b1, 64'd0, ill, rd);
    check(!ill && rd == time_v, "R1 time", rd, time_v);

    // Read-only user counters (R6)
    access(12'hC00, 2'd3, 2'd0, 1'b1, 64'd5, ill, rd);
    check(ill, "R6 write x0", 64'(ill), 64'd1);
    access(12'hC00, 2'd3, 2'd1, 1'b0, 64'd5, ill, rd);
    check(ill, "R6 set nonzero src", 64'(ill), 64'd1);
    access(12'hC02, 2'd3, 2'd2, 1'b1, 64'd5, ill, rd);
    check(!ill, "R6 clear x0 read", 64'(ill), 64'd0);

    // Enable register access privilege (R7), illegal leaves state (R9)
    access(12'h306, 2'd1, 2'd0, 1'b0, 64'd0, ill, rd);
    check(ill, "R7 men from S", 64'(ill), 64'd1);
    access(12'h106, 2'd0, 2'd1, 1'b1, 64'd0, ill, rd);
    check(ill, "R7 sen from U", 64'(ill), 64'd1);
    access(12'h106, 2'd3, 2'd1, 1'b1, 64'd0, ill, rd);
    check(!ill && rd == 64'h1F, "R7 sen from M", rd, 64'h1F);
    access(12'h306, 2'd3, 2'd1, 1'b1, 64'd0, ill, rd);
    check(rd == 64'h1F, "R9 men unchanged", rd, 64'h1F);

    // Machine counter writes (R8) and cycle stepping (R1)
    access(12'hB00, 2'd3, 2'd0, 1'b0, 64'h1000, ill, rd);
    access(12'hB00, 2'd3, 2'd1, 1'b1, 64'd0, ill, rd);
    check(rd == 64'h1000, "R8 mcycle write", rd, 64'h1000);
    access(12'hC00, 2'd0, 2'd1, 1'b1, 64'd0, ill, rd2);
    check(rd2 == rd + 1, "R1 cycle step", rd2, rd + 1);
    access(12'hB00, 2'd3, 2'd1, 1'b0, 64'hF0, ill, rd);
    access(12'hB00, 2'd3, 2'd1, 1'b1, 64'd0, ill, rd);
    check(rd == 64'h10F2, "R8 set bits", rd, 64'h10F2);
    access(12'hB00, 2'd3, 2'd2, 1'b0, 64'h1000, ill, rd);
    access(12'hB00, 2'd3, 2'd1, 1'b1, 64'd0, ill, rd);
    check(rd == 64'hF3, "R8 clear bits", rd, 64'hF3);
    access(12'hB00, 2'd1, 2'd1, 1'b1, 64'd0, ill, rd);
    check(ill, "R8 mcycle from S", 64'(ill), 64'd1);
    access(12'hB01, 2'd3, 2'd1, 1'b1, 64'd0, ill, rd);
    check(ill, "R8 no machine time", 64'(ill), 64'd1);

    // Retired-instruction counting (R1, R8)
    access(12'hB02, 2'd3, 2'd0, 1'b0, 64'd5, ill, rd);
    retire = 1'b1;
    repeat (3) @(negedge clk);
    retire = 1'b0;
    access(12'hC02, 2'd1, 2'd1, 1'b1, 64'd0, ill, rd);
    check(!ill && rd == 64'd8, "R1 instret count", rd, 64'd8);

    // Performance counter events (R1)
    hpm_evt = 2'b01;
    repeat (4) @(negedge clk);
    hpm_evt = 2'b10;
    repeat (2) @(negedge clk);
    hpm_evt = 2'b00;
    access(12'hC03, 2'd3, 2'd1, 1'b1, 64'd0, ill, rd);
    check(rd == 64'd4, "R1 hpm3 count", rd, 64'd4);
    access(12'hC04, 2'd3, 2'd1, 1'b1, 64'd0, ill, rd);
    check(rd == 64'd2, "R1 hpm4 count", rd, 64'd2);

    // Unmapped and reserved codes (R9, R10)
    access(12'h123, 2'd3, 2'd1, 1'b1, 64'd0, ill, rd);
    check(ill, "R9 unmapped", 64'(ill), 64'd1);
    access(12'hC00, 2'd2, 2'd1, 1'b1, 64'd0, ill, rd);
    check(ill, "R10 priv 2", 64'(ill), 64'd1);
    access(12'hC00, 2'd3, 2'd3, 1'b1, 64'd0, ill, rd);
    check(ill, "R10 op 3", 64'(ill), 64'd1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule